// File: doc/BRIEF.md
# PWM Fault Protection Guard

This block sits between a timer's waveform outputs and the pins and forces those outputs to a safe state when a fault shows up. Fault sources are a set of event channels, each enabled by its own mask bit, plus a debug-halt request. A small register port programs the channel mask, the recovery policy, whether debug halts count as faults, and the override action. It also exposes a sticky fault flag that software clears by writing 1.

Once a fault has been captured, the outputs stay overridden until the release conditions hold. Release then takes effect only at the timer's periodic update strobe, so normal output resumes on a period boundary. Two recovery policies exist. Latched recovery also waits for software to clear the flag. Cycle-by-cycle recovery waits only for the fault sources to go quiet.

Top module: `pwm_fault_guard`

## Requirements
- R1: Register address 0 holds the channel mask (NCH bits, reset 0). The enabled channels are ORed, so any one enabled channel that is high can raise a fault, and so can several at once.
- R2: Address 1 is the control register. Bits 1:0 hold the action, bit 2 the recovery policy and bit 4 the debug-ignore bit. Bits 7:5 and bit 3 always read 0. Address 2 bit 0 reads the fault flag. Address 3 reads 0. Every field resets to 0.
- R3: Protection is on only while the action field is nonzero. With action 00, no source sets the flag or overrides the outputs.
- R4: Fault sources are sampled on the rising clock edge. The edge that sees an active enabled source sets the flag, and the outputs are overridden from that edge onward.
- R5: A high debug-halt input is a fault source while bit 4 is 0. With bit 4 set, the debug-halt input has no effect.
- R6: Writing 1 to address 2 bit 0 clears the flag. If a fault source is active on that same edge, the flag stays 1.
- R7: With policy 0 (latched), the override ends only at an edge where the update strobe is high, no source is active and the flag is already 0.
- R8: With policy 1 (cycle-by-cycle), the override ends at an edge where the update strobe is high and no source is active, whatever the flag holds.
- R9: While overridden, action 01 drives every output to IDLE_LEVEL and passes the enables through. Action 11 forces every enable to 0 and passes the levels through. Actions 00 and 10 pass everything through. When no override is in force, outputs and enables always equal their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| evtIn | input | NCH | Event channel fault inputs |
| dbgBreak | input | 1 | Debug-halt request |
| updateStb | input | 1 | Timer period update strobe |
| pwmIn | input | NOUT | Waveform levels from the timer |
| pwmOeIn | input | NOUT | Output enables from the timer |
| pwmOut | output | NOUT | Waveform levels to the pins |
| pwmOe | output | NOUT | Output enables to the pins |

## Verification
The assertions assume that every input, including event lines and the debug request, is synchronous to clk and stable around the rising edge. They also assume that register writes and the update strobe are single-cycle qualified pulses. The bench changes every input only at the falling edge, and its random phase keeps events sparse and update strobes periodic enough that faults are both captured and released many times. It then mixes in register writes at random addresses, including writes to the reserved bits and flag clears while a fault is still present.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_IDLE = 2'b01,
    ACT_RSVD = 2'b10,
    ACT_HIZ  = 2'b11
  } fault_act_e;

  typedef struct packed {
    fault_act_e action;
    logic       cbcMode;
    logic       dbgIgnore;
  } guard_cfg_t;

  typedef struct packed {
    logic forceIdle;
    logic forceOff;
  } guard_strobe_t;

  localparam int REG_DW = 8;
  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

endpackage

// File: rtl/fault_guard_ctrl.sv
module fault_guard_ctrl
  import fault_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          faultHit,
  input  logic          flagClr,
  input  logic          updateStb,
  input  fault_act_e    action,
  input  logic          cbcMode,
  output logic          flag,
  output guard_strobe_t strobe
);

  logic inFault;
  logic releaseOk;

  // release needs the update strobe; latched policy also needs a cleared flag
  assign releaseOk = updateStb && (cbcMode || !flag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag    <= 1'b0;
      inFault <= 1'b0;
    end else begin
      if (faultHit)     flag <= 1'b1;
      else if (flagClr) flag <= 1'b0;

      if (faultHit)       inFault <= 1'b1;
      else if (releaseOk) inFault <= 1'b0;
    end
  end

  always_comb begin
    strobe.forceIdle = inFault && (action == ACT_IDLE);
    strobe.forceOff  = inFault && (action == ACT_HIZ);
  end

  // R4: a captured fault sets the flag and the override
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    faultHit |=> flag);
  a_r4_override_set: assert property (@(posedge clk) disable iff (!rstN)
    faultHit |=> inFault);
  // R6: the flag only drops on a clear request
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    flag && !flagClr |=> flag);
  // R7: latched policy keeps the override while the flag is set
  a_r7_latched_hold: assert property (@(posedge clk) disable iff (!rstN)
    inFault && !cbcMode && flag |=> inFault);
  // R8: no release without an update strobe
  a_r8_needs_update: assert property (@(posedge clk) disable iff (!rstN)
    inFault && !updateStb |=> inFault);

endmodule

// File: rtl/fault_guard_datapath.sv
module fault_guard_datapath
  import fault_guard_pkg::*;
#(
  parameter int NCH = 8,
  parameter int NOUT = 4,
  parameter logic [NOUT-1:0] IDLE_LEVEL = 4'b1010
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [1:0]          regAddr,
  input  logic [REG_DW-1:0]   regWdata,
  output logic [REG_DW-1:0]   regRdata,
  input  logic [NCH-1:0]      evtIn,
  input  logic                dbgBreak,
  input  logic                flag,
  input  guard_strobe_t       strobe,
  input  logic [NOUT-1:0]     pwmIn,
  input  logic [NOUT-1:0]     pwmOeIn,
  output logic [NOUT-1:0]     pwmOut,
  output logic [NOUT-1:0]     pwmOe,
  output guard_cfg_t          cfg,
  output logic [NCH-1:0]      evtMask,
  output logic                faultHit,
  output logic                flagClr
);

  logic protOn;
  logic evtAny;
  logic dbgFault;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtMask <= '0;
      cfg     <= '{action: ACT_NONE, cbcMode: 1'b0, dbgIgnore: 1'b0};
    end else if (regWe) begin
      if (regAddr == ADDR_MASK) evtMask <= regWdata[NCH-1:0];
      if (regAddr == ADDR_CTRL) begin
        cfg.action    <= fault_act_e'(regWdata[1:0]);
        cfg.cbcMode   <= regWdata[2];
        cfg.dbgIgnore <= regWdata[4];
      end
    end
  end

  assign flagClr  = regWe && (regAddr == ADDR_STAT) && regWdata[0];
  assign protOn   = (cfg.action != ACT_NONE);
  assign evtAny   = |(evtIn & evtMask);
  assign dbgFault = dbgBreak && !cfg.dbgIgnore;
  assign faultHit = protOn && (evtAny || dbgFault);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_MASK: regRdata[NCH-1:0] = evtMask;
      ADDR_CTRL: regRdata = {3'b000, cfg.dbgIgnore, 1'b0, cfg.cbcMode, cfg.action};
      ADDR_STAT: regRdata[0] = flag;
      default:   regRdata = '0;
    endcase
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_pin
    assign pwmOut[i] = strobe.forceIdle ? IDLE_LEVEL[i] : pwmIn[i];
    assign pwmOe[i]  = strobe.forceOff ? 1'b0 : pwmOeIn[i];
  end

  // R9: the two override kinds never act together
  a_r9_one_override: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.forceIdle, strobe.forceOff}));

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import fault_guard_pkg::*;
#(
  parameter int NCH = 8,
  parameter int NOUT = 4,
  parameter logic [NOUT-1:0] IDLE_LEVEL = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic [NCH-1:0]    evtIn,
  input  logic              dbgBreak,
  input  logic              updateStb,
  input  logic [NOUT-1:0]   pwmIn,
  input  logic [NOUT-1:0]   pwmOeIn,
  output logic [NOUT-1:0]   pwmOut,
  output logic [NOUT-1:0]   pwmOe
);

  guard_cfg_t    cfg;
  guard_strobe_t strobe;
  logic [NCH-1:0] evtMask;
  logic faultHit;
  logic flagClr;
  logic flag;

  fault_guard_datapath #(.NCH(NCH), .NOUT(NOUT), .IDLE_LEVEL(IDLE_LEVEL)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtIn(evtIn),
    .dbgBreak(dbgBreak), .flag(flag), .strobe(strobe), .pwmIn(pwmIn),
    .pwmOeIn(pwmOeIn), .pwmOut(pwmOut), .pwmOe(pwmOe), .cfg(cfg),
    .evtMask(evtMask), .faultHit(faultHit), .flagClr(flagClr)
  );

  fault_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .faultHit(faultHit), .flagClr(flagClr),
    .updateStb(updateStb), .action(cfg.action), .cbcMode(cfg.cbcMode),
    .flag(flag), .strobe(strobe)
  );

  // R1: any enabled, high channel with protection on raises the flag
  a_r1_mask_or: assert property (@(posedge clk) disable iff (!rstN)
    (|(evtIn & evtMask)) && (cfg.action != ACT_NONE) |=> flag);

endmodule

// File: tb/test_pwm_fault_guard.sv
`timescale 1ns/100ps
module test_pwm_fault_guard;
  localparam int NCH = 8;
  localparam int NOUT = 4;
  localparam logic [3:0] IDLE = 4'b1010;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] evtIn = '0;
  logic dbgBreak = 1'b0;
  logic updateStb = 1'b0;
  logic [3:0] pwmIn = 4'b1100;
  logic [3:0] pwmOeIn = 4'hF;
  logic [7:0] regRdata;
  logic [3:0] pwmOut;
  logic [3:0] pwmOe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] mMask = '0;
  logic [7:0] mCtrl = '0;
  logic mFlag = 1'b0;
  logic mIn = 1'b0;

  pwm_fault_guard #(.NCH(NCH), .NOUT(NOUT), .IDLE_LEVEL(IDLE)) i_pwm_fault_guard (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtIn(evtIn),
    .dbgBreak(dbgBreak), .updateStb(updateStb), .pwmIn(pwmIn),
    .pwmOeIn(pwmOeIn), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] fExpOut();
    return (mIn && mCtrl[1:0] == 2'b01) ? IDLE : pwmIn;
  endfunction

  function automatic logic [3:0] fExpOe();
    return (mIn && mCtrl[1:0] == 2'b11) ? 4'h0 : pwmOeIn;
  endfunction

  function automatic logic [7:0] fExpRd();
    case (regAddr)
      2'd0: return mMask;
      2'd1: return mCtrl;
      2'd2: return {7'b0, mFlag};
      default: return 8'h00;
    endcase
  endfunction

  // compare against the model, advance the model, then move to the next falling edge
  task automatic step();
    logic hit, clr, nIn, nFlag;
    #0.5;
    chk("R9 pins", {4'h0, pwmOut}, {4'h0, fExpOut()});
    chk("R9 enables", {4'h0, pwmOe}, {4'h0, fExpOe()});
    chk("R2 readback", regRdata, fExpRd());
    hit = (mCtrl[1:0] != 2'b00) && (((evtIn & mMask) != 0) || (dbgBreak && !mCtrl[4]));
    clr = regWe && regAddr == 2'd2 && regWdata[0];
    nIn = hit ? 1'b1 : ((updateStb && (mCtrl[2] || !mFlag)) ? 1'b0 : mIn);
    nFlag = hit ? 1'b1 : (clr ? 1'b0 : mFlag);
    @(posedge clk);
    mIn = nIn;
    mFlag = nFlag;
    if (regWe && regAddr == 2'd0) mMask = regWdata;
    if (regWe && regAddr == 2'd1) mCtrl = regWdata & 8'h17;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    step();
    regWe = 1'b0;
  endtask

  task automatic recover();
    evtIn = '0; dbgBreak = 1'b0;
    wr(2'd2, 8'h01);
    updateStb = 1'b1; step(); updateStb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: reset values of every address
    regAddr = 2'd0; step();
    regAddr = 2'd1; step();
    regAddr = 2'd2; #0.5; chk("R2 reset flag", regRdata, 8'h00);
    step();

    // R3: action 00 disables protection
    wr(2'd0, 8'hFF);
    evtIn = 8'hFF; step(); evtIn = '0;
    regAddr = 2'd2; #0.5;
    chk("R3 flag stays 0", regRdata, 8'h00);
    chk("R3 pins pass", {4'h0, pwmOut}, 8'h0C);

    // R1 R4 R7: latched, drive idle
    wr(2'd1, 8'h01);
    evtIn = 8'h04; step(); evtIn = '0;
    regAddr = 2'd2; #0.5;
    chk("R4 flag set", regRdata, 8'h01);
    chk("R1 single channel faults", {4'h0, pwmOut}, {4'h0, IDLE});
    updateStb = 1'b1; step(); updateStb = 1'b0; #0.5;
    chk("R7 holds with flag set", {4'h0, pwmOut}, {4'h0, IDLE});
    wr(2'd2, 8'h01); #0.5;
    chk("R7 holds until update", {4'h0, pwmOut}, {4'h0, IDLE});
    updateStb = 1'b1; step(); updateStb = 1'b0; #0.5;
    chk("R7 released", {4'h0, pwmOut}, 8'h0C);

    // R6: clear during an active source
    evtIn = 8'h04; regWe = 1'b1; regAddr = 2'd2; regWdata = 8'h01;
    step(); regWe = 1'b0; evtIn = '0; #0.5;
    chk("R6 flag kept", regRdata, 8'h01);
    recover();

    // R8: cycle-by-cycle without flag clear
    wr(2'd1, 8'h05);
    evtIn = 8'h80; step(); evtIn = '0;
    updateStb = 1'b1; step(); updateStb = 1'b0; regAddr = 2'd2; #0.5;
    chk("R8 released", {4'h0, pwmOut}, 8'h0C);
    chk("R8 flag still set", regRdata, 8'h01);
    wr(2'd2, 8'h01);

    // R5: debug halt as fault, and suppressed
    wr(2'd0, 8'h00); wr(2'd1, 8'h01);
    dbgBreak = 1'b1; step(); dbgBreak = 1'b0; #0.5;
    chk("R5 debug faults", {4'h0, pwmOut}, {4'h0, IDLE});
    recover();
    wr(2'd1, 8'h11);
    dbgBreak = 1'b1; step(); dbgBreak = 1'b0; regAddr = 2'd2; #0.5;
    chk("R5 debug ignored pins", {4'h0, pwmOut}, 8'h0C);
    chk("R5 debug ignored flag", regRdata, 8'h00);

    // R9: tri-state and reserved action
    wr(2'd1, 8'h03);
    dbgBreak = 1'b1; step(); dbgBreak = 1'b0; #0.5;
    chk("R9 enables off", {4'h0, pwmOe}, 8'h00);
    chk("R9 levels pass", {4'h0, pwmOut}, 8'h0C);
    recover();
    wr(2'd1, 8'h02);
    dbgBreak = 1'b1; step(); dbgBreak = 1'b0; regAddr = 2'd2; #0.5;
    chk("R9 reserved no override", {4'h0, pwmOe}, 8'h0F);
    chk("R9 reserved flag set", regRdata, 8'h01);
    recover();

    // R2: reserved bits and unused address
    wr(2'd1, 8'hFF); regAddr = 2'd1; #0.5;
    chk("R2 reserved bits zero", regRdata, 8'h17);
    wr(2'd3, 8'hFF); #0.5;
    chk("R2 address 3 zero", regRdata, 8'h00);
    wr(2'd1, 8'h00);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      regWe = ($urandom % 8) == 0;
      regAddr = 2'($urandom);
      regWdata = 8'($urandom);
      evtIn = (($urandom % 6) == 0) ? 8'($urandom) : 8'h00;
      dbgBreak = ($urandom % 20) == 0;
      updateStb = ($urandom % 5) == 0;
      pwmIn = 4'($urandom);
      pwmOeIn = 4'($urandom);
      step();
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule